// File: doc/BRIEF.md
# Firmware Call Entry Dispatcher

This block sits behind an instruction pipeline and turns a trap request into a handler selection. Each request carries an exception index. The block sorts the index into one of three kinds: a fixed exception vector, a call from the low call window or a call from the high call window. Any index outside these ranges counts as an internal error. For a call, the block recovers a normalised 8-bit call number from the index. The call windows use a stride of 64 index values per call. Every call number below 0x80 is reserved for kernel mode. If such a number arrives while the current-mode field is non-zero, the block raises a privilege fault and does not dispatch.

The block also runs the swap-handler call itself. A swap can choose one of three built-in handler personalities. It can also load an external handler entry address into the handler base register and redirect the program counter there. Some argument values are reserved; for those the block reports an unknown-identifier result and changes nothing. Coming out of reset, the block is in the state that a swap to built-in personality 0 leaves. Each result appears one clock after the request is sampled.

Top module: `fw_call_dispatch`

## Requirements
- R1: An index from 0 to 11 dispatches a fixed vector one cycle later: disp_valid=1, disp_kind=1 and vec_id equal to the index.
- R2: An index in [0x2000, 0x4000) gives call number (index − 0x2000) >> 6. The low six index bits are ignored. The call dispatches with disp_kind=2.
- R3: An index in [0x4000, 0x6000) gives call number ((index − 0x4000) >> 6) + 0x80. It dispatches with disp_kind=2 in every mode.
- R4: A call number below 0x80 while cur_mode is non-zero raises priv_fault for one cycle. It gives no dispatch, no swap and no change to epc_out.
- R5: An index from 12 to 0x1FFF, or from 0x6000 upward, raises int_err for one cycle and gives no dispatch. In any cycle, at most one of disp_valid, priv_fault and int_err is high.
- R6: On every dispatch, epc_out takes epc_in with bit 0 cleared. With no dispatch, epc_out holds its value.
- R7: A dispatched call number 0x0A with arg 0, 1 or 2 does four things: it sets hsel to arg and hsel_builtin to 1, sets hbase to all ones, and pulses hreset.
- R8: A swap with arg from 3 to 255 sets result_valid with result=1 for one cycle. It leaves hsel, hsel_builtin and hbase unchanged.
- R9: A swap with arg above 255 clears hsel_builtin, keeps hsel and loads arg into hbase. It also pulses redir_valid with redir_addr=arg.
- R10: During reset: hsel=0, hsel_builtin=1, hbase is all ones and hreset=1. All pulse outputs and epc_out are 0.
- R11: A cycle without req_valid produces no dispatch, fault, error, swap or redirect in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Trap request present |
| exc_index | input | 16 | Exception index |
| cur_mode | input | 2 | Current-mode field of processor status (0 = kernel) |
| arg | input | 64 | Argument register value (swap identifier or address) |
| epc_in | input | 64 | Saved exception address |
| disp_valid | output | 1 | Dispatch pulse |
| disp_kind | output | 2 | 1 = fixed vector, 2 = firmware call |
| vec_id | output | 4 | Fixed vector number |
| call_num | output | 8 | Normalised call number |
| priv_fault | output | 1 | Privilege violation pulse |
| int_err | output | 1 | Undefined index pulse |
| epc_out | output | 64 | Saved exception address with bit 0 cleared |
| hsel | output | 2 | Selected built-in personality |
| hsel_builtin | output | 1 | A built-in personality is active |
| hbase | output | 64 | Handler base register |
| hreset | output | 1 | Built-in personality reset pulse |
| redir_valid | output | 1 | PC redirect pulse |
| redir_addr | output | 64 | PC redirect target |
| result_valid | output | 1 | Result register write pulse |
| result | output | 64 | Result value (1 = unknown identifier) |

## Verification
Assertions check several properties on every cycle: the three outcomes never coincide, an even saved address accompanies each dispatch, and low call numbers dispatch only from kernel mode. They also check that a redirect always matches the base register, that a reserved identifier leaves the handler state frozen, and that a personality reset coincides with an all-ones base. Only the bench's scenarios show the exact call-number arithmetic at the window edges (0x2000, 0x3FFF, 0x4000, 0x5FFF, 0x6000). The same holds for the 2/3 and 255/256 boundaries of the swap decode and for a sequence of swaps that moves from an address back to a built-in personality.

// File: rtl/fw_call_pkg.sv
package fw_call_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_FIXED = 2'd1,
    KIND_CALL  = 2'd2
  } disp_kind_e;

  typedef enum logic [1:0] {
    CLS_FIXED   = 2'd0,
    CLS_CALL_LO = 2'd1,
    CLS_CALL_HI = 2'd2,
    CLS_BAD     = 2'd3
  } idx_class_e;
endpackage

// File: rtl/fw_call_classify.sv
module fw_call_classify
  import fw_call_pkg::*;
#(
  parameter int IDX_W     = 16,
  parameter int CALL_W    = 8,
  parameter int VEC_W     = 4,
  parameter int NUM_FIXED = 12,
  parameter int STRIDE_SH = 6,
  parameter int LO_BASE   = 'h2000
) (
  input  logic [IDX_W-1:0]  idx,
  output idx_class_e        cls,
  output logic [VEC_W-1:0]  vec,
  output logic [CALL_W-1:0] num
);
  localparam int HALF    = 1 << (CALL_W - 1);
  localparam int WIN     = HALF << STRIDE_SH;
  localparam int HI_BASE = LO_BASE + WIN;
  localparam int END_IDX = HI_BASE + WIN;

  // Ranges are disjoint; the fixed vectors sit at the very bottom of the index space.
  always_comb begin
    cls = CLS_BAD;
    vec = '0;
    num = '0;
    if (idx < IDX_W'(NUM_FIXED)) begin
      cls = CLS_FIXED;
      vec = VEC_W'(idx);
    end else if (idx >= IDX_W'(LO_BASE) && idx < IDX_W'(HI_BASE)) begin
      cls = CLS_CALL_LO;
      num = CALL_W'((idx - IDX_W'(LO_BASE)) >> STRIDE_SH);
    end else if (idx >= IDX_W'(HI_BASE) && idx < IDX_W'(END_IDX)) begin
      cls = CLS_CALL_HI;
      num = CALL_W'((idx - IDX_W'(HI_BASE)) >> STRIDE_SH) | CALL_W'(HALF);
    end
  end
endmodule

// File: rtl/fw_call_swap.sv
module fw_call_swap #(
  parameter int XLEN        = 64,
  parameter int SEL_W       = 2,
  parameter int NUM_BUILTIN = 3,
  parameter int ID_MAX      = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap_en,
  input  logic [XLEN-1:0]  arg,
  output logic [SEL_W-1:0] sel,
  output logic             builtin,
  output logic [XLEN-1:0]  base,
  output logic             hreset,
  output logic             redir_valid,
  output logic [XLEN-1:0]  redir_addr,
  output logic             result_valid
);
  logic [SEL_W-1:0] sel_d;
  logic             bi_d, hrst_d, redir_d, res_d;
  logic [XLEN-1:0]  base_d, raddr_d;

  // Three-way decode of the swap argument: built-in id, reserved id, entry address.
  always_comb begin
    sel_d   = sel;
    bi_d    = builtin;
    base_d  = base;
    hrst_d  = 1'b0;
    redir_d = 1'b0;
    raddr_d = '0;
    res_d   = 1'b0;
    if (swap_en) begin
      if (arg < XLEN'(NUM_BUILTIN)) begin
        sel_d  = SEL_W'(arg);
        bi_d   = 1'b1;
        base_d = '1;
        hrst_d = 1'b1;
      end else if (arg <= XLEN'(ID_MAX)) begin
        res_d = 1'b1;
      end else begin
        bi_d    = 1'b0;
        base_d  = arg;
        redir_d = 1'b1;
        raddr_d = arg;
      end
    end
  end

  // Reset state equals the outcome of a swap to built-in personality 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel          <= '0;
      builtin      <= 1'b1;
      base         <= '1;
      hreset       <= 1'b1;
      redir_valid  <= 1'b0;
      redir_addr   <= '0;
      result_valid <= 1'b0;
    end else begin
      sel          <= sel_d;
      builtin      <= bi_d;
      base         <= base_d;
      hreset       <= hrst_d;
      redir_valid  <= redir_d;
      redir_addr   <= raddr_d;
      result_valid <= res_d;
    end
  end

  assert_builtin_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hreset |-> (builtin && base == '1));
  assert_reserved_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ($stable(base) && $stable(builtin) && $stable(sel)));
  assert_redirect_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (!builtin && base == redir_addr));
endmodule

// File: rtl/fw_call_dispatch.sv
module fw_call_dispatch
  import fw_call_pkg::*;
#(
  parameter int IDX_W       = 16,
  parameter int XLEN        = 64,
  parameter int MODE_W      = 2,
  parameter int CALL_W      = 8,
  parameter int VEC_W       = 4,
  parameter int NUM_FIXED   = 12,
  parameter int STRIDE_SH   = 6,
  parameter int LO_BASE     = 'h2000,
  parameter int SWAP_NUM    = 'h0A,
  parameter int SEL_W       = 2,
  parameter int NUM_BUILTIN = 3,
  parameter int ID_MAX      = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  exc_index,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [XLEN-1:0]   arg,
  input  logic [XLEN-1:0]   epc_in,
  output logic              disp_valid,
  output logic [1:0]        disp_kind,
  output logic [VEC_W-1:0]  vec_id,
  output logic [CALL_W-1:0] call_num,
  output logic              priv_fault,
  output logic              int_err,
  output logic [XLEN-1:0]   epc_out,
  output logic [SEL_W-1:0]  hsel,
  output logic              hsel_builtin,
  output logic [XLEN-1:0]   hbase,
  output logic              hreset,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_addr,
  output logic              result_valid,
  output logic [XLEN-1:0]   result
);
  localparam int HALF    = 1 << (CALL_W - 1);
  localparam int HI_BASE = LO_BASE + (HALF << STRIDE_SH);

  idx_class_e        cls;
  logic [VEC_W-1:0]  c_vec;
  logic [CALL_W-1:0] c_num;

  fw_call_classify #(
    .IDX_W(IDX_W), .CALL_W(CALL_W), .VEC_W(VEC_W), .NUM_FIXED(NUM_FIXED),
    .STRIDE_SH(STRIDE_SH), .LO_BASE(LO_BASE)
  ) u_classify (
    .idx(exc_index), .cls(cls), .vec(c_vec), .num(c_num)
  );

  logic              dv_d, pf_d, ie_d, swap_en;
  disp_kind_e        kind_d;
  logic [VEC_W-1:0]  vec_d;
  logic [CALL_W-1:0] num_d;
  logic [XLEN-1:0]   epc_d;

  always_comb begin
    dv_d   = 1'b0;
    kind_d = KIND_NONE;
    vec_d  = '0;
    num_d  = '0;
    pf_d   = 1'b0;
    ie_d   = 1'b0;
    epc_d  = epc_out;
    if (req_valid) begin
      unique case (cls)
        CLS_FIXED: begin
          dv_d   = 1'b1;
          kind_d = KIND_FIXED;
          vec_d  = c_vec;
        end
        CLS_CALL_LO, CLS_CALL_HI: begin
          if (c_num < CALL_W'(HALF) && cur_mode != '0) begin
            pf_d = 1'b1;
          end else begin
            dv_d   = 1'b1;
            kind_d = KIND_CALL;
            num_d  = c_num;
          end
        end
        default: ie_d = 1'b1;
      endcase
      if (dv_d) epc_d = epc_in & ~XLEN'(1);
    end
    swap_en = dv_d && kind_d == KIND_CALL && c_num == CALL_W'(SWAP_NUM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_kind  <= KIND_NONE;
      vec_id     <= '0;
      call_num   <= '0;
      priv_fault <= 1'b0;
      int_err    <= 1'b0;
      epc_out    <= '0;
    end else begin
      disp_valid <= dv_d;
      disp_kind  <= kind_d;
      vec_id     <= vec_d;
      call_num   <= num_d;
      priv_fault <= pf_d;
      int_err    <= ie_d;
      epc_out    <= epc_d;
    end
  end

  fw_call_swap #(
    .XLEN(XLEN), .SEL_W(SEL_W), .NUM_BUILTIN(NUM_BUILTIN), .ID_MAX(ID_MAX)
  ) u_swap (
    .clk(clk), .rst_n(rst_n), .swap_en(swap_en), .arg(arg),
    .sel(hsel), .builtin(hsel_builtin), .base(hbase), .hreset(hreset),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .result_valid(result_valid)
  );

  assign result = result_valid ? XLEN'(1) : '0;

  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({disp_valid, priv_fault, int_err}));
  assert_kernel_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_kind == KIND_CALL && call_num < CALL_W'(HALF))
      |-> $past(cur_mode) == '0);
  assert_epc_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !epc_out[0]);
  assert_high_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_kind == KIND_CALL && $past(exc_index) >= IDX_W'(HI_BASE))
      |-> call_num[CALL_W-1]);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(disp_valid || priv_fault || int_err || redir_valid || result_valid));
endmodule

// File: tb/fw_call_dispatch_bench.sv
module fw_call_dispatch_bench;
  typedef struct packed {
    logic        dv;
    logic [1:0]  kind;
    logic [3:0]  vec;
    logic [7:0]  num;
    logic        pf;
    logic        ie;
    logic        prst;
    logic        redir;
    logic        resv;
    logic [1:0]  sel;
    logic        bi;
    logic [63:0] base;
    logic [63:0] raddr;
    logic [63:0] epc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] exc_index = '0;
  logic [1:0]  cur_mode = '0;
  logic [63:0] arg = '0;
  logic [63:0] epc_in = '0;
  logic        disp_valid, priv_fault, int_err, hsel_builtin, hreset, redir_valid, result_valid;
  logic [1:0]  disp_kind, hsel;
  logic [3:0]  vec_id;
  logic [7:0]  call_num;
  logic [63:0] epc_out, hbase, redir_addr, result;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  exp_t  q[$];
  string tq[$];

  // Independent model state
  logic [1:0]  m_sel = 2'd0;
  logic        m_bi = 1'b1;
  logic [63:0] m_base = '1;
  logic [63:0] m_epc = '0;

  always #5 clk = ~clk;

  fw_call_dispatch u_fw_call_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .exc_index(exc_index),
    .cur_mode(cur_mode), .arg(arg), .epc_in(epc_in), .disp_valid(disp_valid),
    .disp_kind(disp_kind), .vec_id(vec_id), .call_num(call_num), .priv_fault(priv_fault),
    .int_err(int_err), .epc_out(epc_out), .hsel(hsel), .hsel_builtin(hsel_builtin),
    .hbase(hbase), .hreset(hreset), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .result_valid(result_valid), .result(result)
  );

  function automatic exp_t actual();
    exp_t a;
    a.dv = disp_valid; a.kind = disp_kind; a.vec = vec_id; a.num = call_num;
    a.pf = priv_fault; a.ie = int_err; a.prst = hreset; a.redir = redir_valid;
    a.resv = result_valid && (result == 64'd1); a.sel = hsel; a.bi = hsel_builtin;
    a.base = hbase; a.raddr = redir_addr; a.epc = epc_out;
    return a;
  endfunction

  task automatic check(input string tag, input exp_t e);
    exp_t a;
    a = actual();
    compared++;
    if (a !== e || (!result_valid && result !== 64'd0)) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, a, e);
    end
  endtask

  // Driver: applies one request at a negedge and queues the model's expectation.
  task automatic drive(input bit v, input logic [15:0] idx, input logic [1:0] mode,
                       input logic [63:0] a, input logic [63:0] ep, input string tag);
    exp_t e;
    logic [7:0] n;
    bit disp, call;
    @(negedge clk);
    req_valid = v; exc_index = idx; cur_mode = mode; arg = a; epc_in = ep;
    e = '0; disp = 0; call = 0; n = '0;
    if (v) begin
      if (idx < 16'd12) begin
        disp = 1; e.kind = 2'd1; e.vec = idx[3:0];
      end else if (idx >= 16'h2000 && idx < 16'h4000) begin
        n = 8'((idx - 16'h2000) >> 6);
        if (mode != 2'd0) e.pf = 1; else begin disp = 1; call = 1; end
      end else if (idx >= 16'h4000 && idx < 16'h6000) begin
        n = 8'((idx - 16'h4000) >> 6) + 8'h80;
        disp = 1; call = 1;
      end else begin
        e.ie = 1;
      end
    end
    if (disp) begin
      e.dv = 1; m_epc = ep & ~64'd1;
      if (call) begin e.kind = 2'd2; e.num = n; end
    end
    if (call && n == 8'h0A) begin
      if (a < 64'd3) begin
        m_sel = a[1:0]; m_bi = 1; m_base = '1; e.prst = 1;
      end else if (a <= 64'd255) begin
        e.resv = 1;
      end else begin
        m_bi = 0; m_base = a; e.redir = 1; e.raddr = a;
      end
    end
    e.sel = m_sel; e.bi = m_bi; e.base = m_base; e.epc = m_epc;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  // Monitor: compares one queued item just after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) check(tq.pop_front(), q.pop_front());
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r = '0; r.prst = 1; r.bi = 1; r.base = '1;
    check("R10 reset state", r);
    rst_n = 1'b1;
    drive(0, 16'h0000, 0, 0, 0, "R11 idle after reset");
    drive(0, 16'h2280, 0, 64'd1, 0, "R11 idle with stale inputs");
    drive(1, 16'd0, 0, 0, 64'h11, "R1 fixed vector 0 and R6 epc cleared");
    drive(1, 16'd5, 2, 0, 64'h2003, "R1 fixed vector 5");
    drive(1, 16'd11, 0, 0, 64'h40, "R1 fixed vector 11");
    drive(1, 16'd12, 0, 0, 64'h77, "R5 index 12 undefined");
    drive(1, 16'h1FFF, 0, 0, 0, "R5 index 0x1FFF undefined");
    drive(1, 16'h2000, 0, 0, 64'h101, "R2 low window start");
    drive(1, 16'h2147, 0, 0, 0, "R2 low bits ignored");
    drive(1, 16'h3FFF, 0, 0, 0, "R2 low window end");
    drive(1, 16'h2147, 3, 0, 64'h999, "R4 user mode low call faults");
    drive(1, 16'h2040, 1, 0, 0, "R4 mode 1 low call faults");
    drive(1, 16'h4000, 3, 0, 64'h5, "R3 high window start user mode");
    drive(1, 16'h40C0, 1, 0, 0, "R3 call 0x83");
    drive(1, 16'h5FFF, 0, 0, 0, "R3 high window end");
    drive(1, 16'h6000, 0, 0, 0, "R5 index 0x6000 undefined");
    drive(1, 16'hFFFF, 0, 0, 0, "R5 index 0xFFFF undefined");
    drive(1, 16'h2280, 0, 64'd2, 0, "R7 swap to built-in 2");
    drive(1, 16'h2280, 0, 64'd200, 0, "R8 reserved id 200");
    drive(1, 16'h2280, 0, 64'h1234_5678_0000, 0, "R9 swap to entry address");
    drive(1, 16'h2280, 0, 64'd3, 0, "R8 reserved id 3 keeps address");
    drive(1, 16'h2280, 0, 64'd255, 0, "R8 reserved id 255");
    drive(1, 16'h2280, 0, 64'd256, 0, "R9 address 256");
    drive(1, 16'h2280, 2, 64'd1, 0, "R4 swap from user mode refused");
    drive(1, 16'h2280, 0, 64'd0, 64'h3, "R7 swap back to built-in 0");
    drive(1, 16'h22BF, 0, 64'd1, 0, "R7 swap to built-in 1 with low bits set");
    drive(0, 16'h2280, 0, 64'd2, 0, "R11 idle after swaps");
    drive(1, 16'd7, 0, 0, 64'hFFFF, "R6 epc bit0 cleared again");
    drive(0, 16'h0, 0, 0, 0, "R11 final idle");
    drive(0, 16'h0, 0, 0, 0, "R11 drain");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule